// File: doc/BRIEF.md
# Self-Timed SRAM Access Sequencer

This block drives one access at a time into a 1024-word by 32-bit SRAM macro built from cells with separate read and write ports. A command is taken when the chip enable is high. The write enable chooses between a read and a write. The address, the write data and the operation type are captured at that moment. The block then steps through a short phase sequence that drives the decoder enables, the bitline equalize strobe, the replica-bitline precharge, the two wordline driver enables and the local read-amplifier pass enable.

Wordline pulses are not timed by a delay chain. A write pulse ends when the write replica reports that the cells have tripped. A read runs in two stages. The first stage ends when the read replica detects a zero. The second ends when the global read path signals completion, and the read word is captured at that point. A programmable cycle limit acts as a fallback for each wait stage: when it runs out, the wordline is forced off and a sticky error flag is raised.

Top module: `sram_access_seq`

## Requirements
- R1: While `ce` is low, no access starts, whatever `we` and `addr` show. `busy`, every wordline, strobe and decoder enable stay 0.
- R2: In the idle phase, `ce`=1 with `we`=0 starts a read and `ce`=1 with `we`=1 starts a write. `arr_addr` (and `arr_wdata` for a write) holds the captured values until the access ends, whatever the inputs do. A command presented while `busy` is 1 is dropped.
- R3: The first cycle of a write is an equalize cycle: `eq_en`=1, `wdata_drv_en`=1 and `wwl_en`=0. `wwl_en` rises in the next cycle and `wdata_drv_en` stays 1 while it is high. No precharge strobe is given.
- R4: `wwl_en` falls in the cycle after `wr_trip` is sampled high. There follows exactly one cycle with `acc_done`=1, and after that `busy` is 0.
- R5: The first cycle of a read pulses `rrep_pre_en` (replica bitline precharge). In the next cycle `rwl_en` and `lsa_en` rise together.
- R6: `lsa_en` falls in the cycle after `rd_zero` is sampled high. `rwl_en` stays high until the global completion.
- R7: When `grd_done` is sampled high, `grd_data` is captured and `rwl_en` falls. In the following `acc_done` cycle, `rdata_vld`=1 and `rdata` holds the captured word.
- R8: If a wait stage sees no completion within `tmo_limit` cycles (0 counts as 1), the wordline is dropped and `acc_done` follows. A completion that arrives in the last allowed cycle still wins. `tmo_err` then stays 1 until reset, and that access gives no `rdata_vld`.
- R9: `row_dec_en` and `col_dec_en` are high from the first phase of an access through its last wordline cycle. They are low when idle and in the `acc_done` cycle.
- R10: After reset, `busy`, `tmo_err`, `rdata_vld`, `acc_done` and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Word address |
| wdata | input | 32 | Write data |
| tmo_limit | input | 8 | Cycle limit per wait stage |
| wr_trip | input | 1 | Write replica reached trip point |
| rd_zero | input | 1 | Read replica detected zero |
| grd_done | input | 1 | Global read path complete |
| grd_data | input | 32 | Global read path data |
| arr_addr | output | 10 | Captured address to decoders |
| arr_wdata | output | 32 | Captured write data |
| row_dec_en | output | 1 | Row decoder enable |
| col_dec_en | output | 1 | Column decoder enable |
| eq_en | output | 1 | Write bitline equalize strobe |
| wdata_drv_en | output | 1 | Write data driver enable |
| wwl_en | output | 1 | Write wordline driver enable |
| rwl_en | output | 1 | Read wordline driver enable |
| rrep_pre_en | output | 1 | Read replica bitline precharge |
| lsa_en | output | 1 | Local read-amplifier pass enable |
| rdata | output | 32 | Captured read word |
| rdata_vld | output | 1 | Read word valid (done cycle) |
| acc_done | output | 1 | Access completion pulse |
| busy | output | 1 | Access in progress |
| tmo_err | output | 1 | Sticky timeout flag |

## Verification
A command sampled at edge 0 shows its equalize or precharge outputs in the cycle after that edge. The wordline enables come one cycle later. A completion sampled at an edge changes the enables in the cycle after that edge, and the `acc_done` cycle directly follows the final completion. `busy` is low one cycle after that. The bench drives inputs and samples outputs on falling edges. It walks each phase with a cycle index k, raises the completion input in the cycle where k equals the chosen delay, and checks each output only in the cycle where the sequence above puts its change. The sweep covers every delay from 1 to beyond the limit, the case where the delay equals the limit, and a limit of 0.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_EQ    = 3'd1,
    S_WL    = 3'd2,
    S_SENSE = 3'd3,
    S_DONE  = 3'd4
  } sas_state_e;
endpackage

// File: rtl/sas_tmo_ctr.sv
module sas_tmo_ctr #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  input  logic [TMO_W-1:0] limit,
  output logic             hit
);
  localparam int CW = TMO_W + 1;

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_d;
  logic [CW-1:0]    elapsed;

  // cycles spent in this wait stage including the current one
  assign elapsed = {1'b0, cnt_q} + CW'(1);
  assign hit     = run && (elapsed >= {1'b0, limit});

  always_comb begin
    if (run && !adv) cnt_d = cnt_q + TMO_W'(1);
    else             cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sas_cmd_reg.sv
module sas_cmd_reg #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              we_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              cap,
  input  logic [DATA_W-1:0] rd_in,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load) begin
      we_q    <= we_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= rd_in;
  end
endmodule

// File: rtl/sas_fsm.sv
module sas_fsm
  import sas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  logic       cmd_we,
  input  logic       wr_trip,
  input  logic       rd_zero,
  input  logic       grd_done,
  input  logic       tmo_hit,
  output sas_state_e state,
  output logic       accept,
  output logic       cap,
  output logic       adv,
  output logic       run,
  output logic       last_tmo,
  output logic       tmo_err
);
  sas_state_e nxt;
  logic       fire;

  always_comb begin
    nxt    = state;
    accept = 1'b0;
    cap    = 1'b0;
    fire   = 1'b0;
    unique case (state)
      S_IDLE: if (ce) begin
        accept = 1'b1;
        nxt    = S_EQ;
      end
      S_EQ: nxt = S_WL;
      S_WL: begin
        if (cmd_we ? wr_trip : rd_zero) nxt = cmd_we ? S_DONE : S_SENSE;
        else if (tmo_hit) begin
          fire = 1'b1;
          nxt  = S_DONE;
        end
      end
      S_SENSE: begin
        if (grd_done) begin
          cap = 1'b1;
          nxt = S_DONE;
        end else if (tmo_hit) begin
          fire = 1'b1;
          nxt  = S_DONE;
        end
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign adv = (nxt != state);
  assign run = (state == S_WL) || (state == S_SENSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tmo_err  <= 1'b0;
      last_tmo <= 1'b0;
    end else begin
      state <= nxt;
      if (fire) tmo_err <= 1'b1;
      if (run && adv) last_tmo <= fire;
    end
  end
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sas_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              wr_trip,
  input  logic              rd_zero,
  input  logic              grd_done,
  input  logic [DATA_W-1:0] grd_data,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              row_dec_en,
  output logic              col_dec_en,
  output logic              eq_en,
  output logic              wdata_drv_en,
  output logic              wwl_en,
  output logic              rwl_en,
  output logic              rrep_pre_en,
  output logic              lsa_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld,
  output logic              acc_done,
  output logic              busy,
  output logic              tmo_err
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  sas_state_e st;
  logic accept, cap, adv, run, last_tmo, tmo_hit, cmd_we;

  sas_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn), .ce(ce), .cmd_we(cmd_we),
    .wr_trip(wr_trip), .rd_zero(rd_zero), .grd_done(grd_done),
    .tmo_hit(tmo_hit), .state(st), .accept(accept), .cap(cap),
    .adv(adv), .run(run), .last_tmo(last_tmo), .tmo_err(tmo_err)
  );

  sas_tmo_ctr #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_sn), .run(run), .adv(adv),
    .limit(tmo_limit), .hit(tmo_hit)
  );

  sas_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_sn), .load(accept), .we_in(we),
    .addr_in(addr), .wdata_in(wdata), .cap(cap), .rd_in(grd_data),
    .we_q(cmd_we), .addr_q(arr_addr), .wdata_q(arr_wdata), .rdata_q(rdata)
  );

  logic in_eq, in_wl, in_sense, in_done;
  assign in_eq    = (st == S_EQ);
  assign in_wl    = (st == S_WL);
  assign in_sense = (st == S_SENSE);
  assign in_done  = (st == S_DONE);

  assign row_dec_en   = in_eq || in_wl || in_sense;
  assign col_dec_en   = in_eq || in_wl || in_sense;
  assign eq_en        = in_eq && cmd_we;
  assign rrep_pre_en  = in_eq && !cmd_we;
  assign wdata_drv_en = cmd_we && (in_eq || in_wl);
  assign wwl_en       = cmd_we && in_wl;
  assign rwl_en       = !cmd_we && (in_wl || in_sense);
  assign lsa_en       = !cmd_we && in_wl;
  assign acc_done     = in_done;
  assign busy         = (st != S_IDLE);
  assign rdata_vld    = in_done && !cmd_we && !last_tmo;
endmodule

// File: rtl/sas_chk.sv
module sas_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_trip,
  input logic              rd_zero,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              row_dec_en,
  input logic              eq_en,
  input logic              wwl_en,
  input logic              rwl_en,
  input logic              rrep_pre_en,
  input logic              lsa_en,
  input logic              rdata_vld,
  input logic              acc_done,
  input logic              busy,
  input logic              tmo_err
);
  // R3
  eq_wl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eq_en && wwl_en));
  // R3
  wwl_after_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wwl_en) |-> $past(eq_en));
  // R4
  wwl_trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_trip && wwl_en) |=> !wwl_en);
  // R4
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !busy);
  // R5
  lsa_in_rwl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsa_en |-> rwl_en);
  // R5
  rwl_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwl_en) |-> $past(rrep_pre_en));
  // R6
  lsa_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_zero && lsa_en) |=> !lsa_en);
  // R7
  vld_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_vld |-> acc_done);
  // R8
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> tmo_err);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_addr));
  // R9
  dec_cover_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wwl_en || rwl_en) |-> row_dec_en);
  // R9
  wl_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wwl_en && rwl_en));
endmodule

bind sram_access_seq sas_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_trip(wr_trip), .rd_zero(rd_zero),
  .arr_addr(arr_addr), .row_dec_en(row_dec_en), .eq_en(eq_en),
  .wwl_en(wwl_en), .rwl_en(rwl_en), .rrep_pre_en(rrep_pre_en),
  .lsa_en(lsa_en), .rdata_vld(rdata_vld), .acc_done(acc_done),
  .busy(busy), .tmo_err(tmo_err)
);

// File: tb/sram_access_seq_tb.sv
module sram_access_seq_tb;
  logic        clk, rst_n, ce, we, wr_trip, rd_zero, grd_done;
  logic [9:0]  addr, arr_addr;
  logic [31:0] wdata, grd_data, arr_wdata, rdata;
  logic [7:0]  tmo_limit;
  logic row_dec_en, col_dec_en, eq_en, wdata_drv_en, wwl_en, rwl_en;
  logic rrep_pre_en, lsa_en, rdata_vld, acc_done, busy, tmo_err;

  int nchk = 0;
  int nfail = 0;
  bit tmo_exp = 0;

  sram_access_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .wdata(wdata),
    .tmo_limit(tmo_limit), .wr_trip(wr_trip), .rd_zero(rd_zero),
    .grd_done(grd_done), .grd_data(grd_data), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .row_dec_en(row_dec_en), .col_dec_en(col_dec_en),
    .eq_en(eq_en), .wdata_drv_en(wdata_drv_en), .wwl_en(wwl_en),
    .rwl_en(rwl_en), .rrep_pre_en(rrep_pre_en), .lsa_en(lsa_en),
    .rdata(rdata), .rdata_vld(rdata_vld), .acc_done(acc_done),
    .busy(busy), .tmo_err(tmo_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // d1: cycle of first completion (0 = never); d2: read global completion
  task automatic run_op(input bit w, input logic [9:0] a, input logic [31:0] dat,
                        input int d1, input int d2, input int lim);
    int leff;
    bit to;
    logic [31:0] rexp;
    leff = (lim == 0) ? 1 : lim;
    rexp = {a, a, a[9:0], 2'b01} ^ 32'h5A3C_96E1;
    to = 0;
    tmo_limit = 8'(lim);
    ce = 1; we = w; addr = a; wdata = dat;
    @(posedge clk); @(negedge clk);
    ce = 0; we = ~w; addr = ~a; wdata = ~dat;
    chk("R2", "busy after accept", busy, 1);
    chk("R2", "captured addr", arr_addr, a);
    chk("R3", "eq_en in first phase", eq_en, w);
    chk("R3", "wdata_drv_en in first phase", wdata_drv_en, w);
    chk("R3", "no wordline in first phase", wwl_en | rwl_en, 0);
    chk("R5", "replica precharge", rrep_pre_en, !w);
    chk("R9", "decoders on", {row_dec_en, col_dec_en}, 2'b11);
    if (w) chk("R2", "captured wdata", arr_wdata, dat);
    for (int k = 1; k <= leff; k++) begin
      @(negedge clk);
      ce = 1; we = ~w; addr = a ^ 10'h155;
      if (w) begin
        chk("R3", "wwl_en on", wwl_en, 1);
        chk("R3", "wdata driven with wwl", wdata_drv_en, 1);
      end else begin
        chk("R5", "rwl and lsa together", {rwl_en, lsa_en}, 2'b11);
      end
      chk("R2", "addr held while busy", arr_addr, a);
      if (k == d1) begin
        if (w) wr_trip = 1; else rd_zero = 1;
      end
      @(posedge clk); #1;
      wr_trip = 0; rd_zero = 0;
      if (k == d1) break;
      if (k == leff) to = 1;
    end
    if (!w && !to) begin
      grd_data = rexp;
      for (int k = 1; k <= leff; k++) begin
        @(negedge clk);
        ce = 1; we = 1;
        chk("R6", "lsa off, rwl held", {rwl_en, lsa_en}, 2'b10);
        if (k == d2) grd_done = 1;
        @(posedge clk); #1;
        grd_done = 0;
        if (k == d2) break;
        if (k == leff) to = 1;
      end
    end
    @(negedge clk);
    ce = 0;
    grd_data = ~rexp;
    tmo_exp = tmo_exp | to;
    chk("R4", "acc_done pulse", acc_done, 1);
    chk("R4", "wordlines off in done", {wwl_en, rwl_en, lsa_en}, 3'b000);
    chk("R9", "decoders off in done", {row_dec_en, col_dec_en}, 2'b00);
    chk("R8", "tmo_err sticky value", tmo_err, tmo_exp);
    chk("R7", "rdata_vld", rdata_vld, (!w && !to));
    if (!w && !to) chk("R7", "rdata word", rdata, rexp);
    @(negedge clk);
    chk("R2", "idle after done, busy command dropped", busy, 0);
    chk("R4", "single done pulse", acc_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    rst_n = 0; ce = 0; we = 0; addr = 0; wdata = 0; tmo_limit = 8'd4;
    wr_trip = 0; rd_zero = 0; grd_done = 0; grd_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "flags after reset", {tmo_err, rdata_vld, acc_done}, 0);
    chk("R10", "enables after reset",
        {row_dec_en, col_dec_en, eq_en, wdata_drv_en, wwl_en, rwl_en, rrep_pre_en, lsa_en}, 0);
    // R1: ce low with write enable and address moving
    for (int i = 0; i < 6; i++) begin
      ce = 0; we = i[0]; addr = 10'(i * 37);
      @(negedge clk);
      chk("R1", "no access with ce low", {busy, eq_en, wwl_en, rwl_en, rrep_pre_en, row_dec_en}, 0);
    end
    // writes, completion at every cycle up to the limit
    for (int d = 1; d <= 5; d++)
      run_op(1, 10'(d * 113), 32'hC0DE_0000 + 32'(d), d, 0, 5);
    // reads, all stage-delay pairs
    for (int d1 = 1; d1 <= 3; d1++)
      for (int d2 = 1; d2 <= 3; d2++)
        run_op(0, 10'(d1 * 300 + d2 * 17), 32'h0, d1, d2, 4);
    // R8: completions in the final allowed cycle still win
    run_op(0, 10'h3FF, 32'h0, 4, 4, 4);
    run_op(1, 10'h000, 32'hFFFF_FFFF, 4, 0, 4);
    // R8: timeouts
    run_op(1, 10'h2A5, 32'h1234_5678, 6, 0, 5);
    run_op(1, 10'h15A, 32'h8765_4321, 0, 0, 0);
    run_op(0, 10'h0F0, 32'h0, 0, 0, 2);
    run_op(0, 10'h30C, 32'h0, 2, 0, 3);
    // normal read after timeouts: flag stays, data still valid
    run_op(0, 10'h1C7, 32'h0, 1, 2, 6);
    summary();
  end
endmodule